// File: doc/BRIEF.md
# Time-Division Memory Wheel Arbiter

This block shares one slow, fixed-latency main memory among several hardware threads. It does not arbitrate on requests. A free-running wheel divides time into equal windows and gives one window to each thread in a fixed circular order. A thread may start an access only in the first cycle of its own window. The access then completes inside that same window. A thread whose request misses that first cycle keeps its request raised, like a stalled instruction that replays, and is served when its window comes round again.

Access timing depends only on the wheel position and on the thread's own request. No thread's traffic can move another thread's latency, and a window whose owner is idle stays unused. Each thread sees a one-cycle grant when its access goes out to memory and a one-cycle done pulse when the result returns. Read data is presented on that thread's data output in the done cycle.

Top module: `mem_wheel_arbiter`

## Requirements
- R1: After reset is released the wheel stands at window 0 (thread 0), cycle 0 of the window, and no grant, done or memory request is driven while no thread requests.
- R2: Windows follow the order thread 0, 1, …, N_THREADS-1 and then repeat, each WIN_CYCLES cycles long. Thread i is granted (thr_grant bit i, one cycle) exactly in the first cycle of its own window when thr_req bit i is high in that cycle, and at no other time.
- R3: mem_req is high exactly in a grant cycle. In that cycle mem_we, mem_addr and mem_wdata equal the granted thread's thr_we bit and its thr_addr and thr_wdata slices (thread i uses bits i*ADDR_W and i*DATA_W upward).
- R4: Each grant is followed by exactly one done pulse for the same thread, one cycle wide, MEM_LAT-1 cycles after the grant cycle and so still inside the thread's window.
- R5: In a done cycle of a read (thr_we low at the grant), the thread's thr_rdata slice carries mem_rdata as returned by a memory that answers MEM_LAT-1 cycles after capture. Outside its done cycles a thread's thr_rdata slice is zero (default variant).
- R6: A request first raised after the opening cycle of the thread's own window is not granted in that window. It is granted at the start of the thread's next window, one full rotation later.
- R7: A window whose owner does not request produces no grant to any thread. The latency of one thread's access is the same whatever the other threads request.
- R8: No new grant is issued while an access is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_req | input | N_THREADS | Per-thread access request, held until done |
| thr_we | input | N_THREADS | Per-thread write enable (1 = write) |
| thr_addr | input | N_THREADS*ADDR_W | Per-thread address, thread i in slice i |
| thr_wdata | input | N_THREADS*DATA_W | Per-thread write data, thread i in slice i |
| thr_grant | output | N_THREADS | One-cycle pulse when the thread's access is issued |
| thr_done | output | N_THREADS | One-cycle pulse when the thread's access completes |
| thr_rdata | output | N_THREADS*DATA_W | Per-thread read data, valid with done |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, fixed latency |

## Verification
The bound assertions check these properties on every cycle:
- at most one grant at a time, and only to a requesting thread;
- the memory strobe coincides with a grant;
- done comes exactly MEM_LAT-1 cycles after a grant, to the same thread, as a single pulse;
- no grant is issued while an access is outstanding.

The property that each grant falls in the opening cycle of its owner's window needs a model of wheel position. Read data correctness, the full-rotation wait of a late request, and the unchanged latency of one thread under load from the others also need such a model. These are shown only by the bench, which runs its own schedule and reference memory over directed and random request patterns.

// File: rtl/mw_pkg.sv
package mw_pkg;
   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_BUSY = 1'b1
   } mw_phase_e;

   // index width that stays at least one bit for degenerate counts
   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/mw_wheel.sv
module mw_wheel #(
   parameter int unsigned N   = 4,
   parameter int unsigned WIN = 13,
   localparam int unsigned OW = mw_pkg::idx_w(N),
   localparam int unsigned SW = mw_pkg::idx_w(WIN)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [OW-1:0] owner,
   output logic [SW-1:0] slot
);
   localparam logic [SW-1:0] SLOT_LAST  = SW'(WIN - 1);
   localparam logic [OW-1:0] OWNER_LAST = OW'(N - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner <= '0;
         slot  <= '0;
      end else if (slot == SLOT_LAST) begin
         slot  <= '0;
         owner <= (owner == OWNER_LAST) ? '0 : owner + OW'(1);
      end else begin
         slot  <= slot + SW'(1);
      end
   end
endmodule

// File: rtl/mw_sel.sv
module mw_sel #(
   parameter int unsigned N  = 4,
   parameter int unsigned AW = 16,
   parameter int unsigned DW = 32,
   localparam int unsigned OW = mw_pkg::idx_w(N)
) (
   input  logic [OW-1:0]   owner,
   input  logic [N-1:0]    req,
   input  logic [N-1:0]    we,
   input  logic [N*AW-1:0] addr,
   input  logic [N*DW-1:0] wdata,
   output logic            sel_req,
   output logic            sel_we,
   output logic [AW-1:0]   sel_addr,
   output logic [DW-1:0]   sel_wdata
);
   logic [N-1:0]         hit;
   logic [N-1:0][AW-1:0] lane_addr;
   logic [N-1:0][DW-1:0] lane_wdata;

   for (genvar g = 0; g < N; g++) begin : g_lane
      assign hit[g]        = (owner == OW'(g));
      assign lane_addr[g]  = hit[g] ? addr[g*AW +: AW]  : '0;
      assign lane_wdata[g] = hit[g] ? wdata[g*DW +: DW] : '0;
   end

   always_comb begin
      sel_addr  = '0;
      sel_wdata = '0;
      for (int i = 0; i < N; i++) begin
         sel_addr  = sel_addr  | lane_addr[i];
         sel_wdata = sel_wdata | lane_wdata[i];
      end
   end

   assign sel_req = |(req & hit);
   assign sel_we  = |(we & hit);
endmodule

// File: rtl/mw_slot_ctl.sv
module mw_slot_ctl
   import mw_pkg::*;
#(
   parameter int unsigned N   = 4,
   parameter int unsigned WIN = 13,
   parameter int unsigned LAT = 13,
   localparam int unsigned OW = mw_pkg::idx_w(N),
   localparam int unsigned SW = mw_pkg::idx_w(WIN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [OW-1:0] owner,
   input  logic [SW-1:0] slot,
   input  logic          sel_req,
   output logic          issue,
   output logic [N-1:0]  grant,
   output logic [N-1:0]  done
);
   localparam logic [SW-1:0] SLOT_DONE = SW'(LAT - 1);

   mw_phase_e phase;
   logic      finish;

   assign issue  = (phase == PH_IDLE) && (slot == '0) && sel_req;
   assign finish = (phase == PH_BUSY) && (slot == SLOT_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      phase <= PH_IDLE;
      else if (issue)  phase <= PH_BUSY;
      else if (finish) phase <= PH_IDLE;
   end

   // owner cannot change between issue and finish: both lie in one window
   for (genvar g = 0; g < N; g++) begin : g_pulse
      assign grant[g] = issue  && (owner == OW'(g));
      assign done[g]  = finish && (owner == OW'(g));
   end
endmodule

// File: rtl/mem_wheel_arbiter.sv
module mem_wheel_arbiter #(
   parameter int unsigned N_THREADS       = 4,
   parameter int unsigned ADDR_W          = 16,
   parameter int unsigned DATA_W          = 32,
   parameter int unsigned MEM_LAT         = 13,
   parameter int unsigned WIN_CYCLES      = MEM_LAT,
   parameter bit          ZERO_IDLE_RDATA = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_THREADS-1:0]          thr_req,
   input  logic [N_THREADS-1:0]          thr_we,
   input  logic [N_THREADS*ADDR_W-1:0]   thr_addr,
   input  logic [N_THREADS*DATA_W-1:0]   thr_wdata,
   output logic [N_THREADS-1:0]          thr_grant,
   output logic [N_THREADS-1:0]          thr_done,
   output logic [N_THREADS*DATA_W-1:0]   thr_rdata,
   output logic                          mem_req,
   output logic                          mem_we,
   output logic [ADDR_W-1:0]             mem_addr,
   output logic [DATA_W-1:0]             mem_wdata,
   input  logic [DATA_W-1:0]             mem_rdata
);
   localparam int unsigned OW = mw_pkg::idx_w(N_THREADS);
   localparam int unsigned SW = mw_pkg::idx_w(WIN_CYCLES);

   if (N_THREADS < 1)          begin : g_bad_n   $error("N_THREADS must be at least 1"); end
   if (ADDR_W < 1)             begin : g_bad_aw  $error("ADDR_W must be at least 1"); end
   if (DATA_W < 1)             begin : g_bad_dw  $error("DATA_W must be at least 1"); end
   if (MEM_LAT < 2)            begin : g_bad_lat $error("MEM_LAT must be at least 2"); end
   if (WIN_CYCLES < MEM_LAT)   begin : g_bad_win $error("WIN_CYCLES must cover MEM_LAT"); end

   logic [OW-1:0]     owner;
   logic [SW-1:0]     slot;
   logic              sel_req;
   logic              sel_we;
   logic [ADDR_W-1:0] sel_addr;
   logic [DATA_W-1:0] sel_wdata;
   logic              issue;

   mw_wheel #(.N(N_THREADS), .WIN(WIN_CYCLES)) u_wheel (
      .clk   (clk),
      .rst_n (rst_n),
      .owner (owner),
      .slot  (slot)
   );

   mw_sel #(.N(N_THREADS), .AW(ADDR_W), .DW(DATA_W)) u_sel (
      .owner     (owner),
      .req       (thr_req),
      .we        (thr_we),
      .addr      (thr_addr),
      .wdata     (thr_wdata),
      .sel_req   (sel_req),
      .sel_we    (sel_we),
      .sel_addr  (sel_addr),
      .sel_wdata (sel_wdata)
   );

   mw_slot_ctl #(.N(N_THREADS), .WIN(WIN_CYCLES), .LAT(MEM_LAT)) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .owner   (owner),
      .slot    (slot),
      .sel_req (sel_req),
      .issue   (issue),
      .grant   (thr_grant),
      .done    (thr_done)
   );

   assign mem_req   = issue;
   assign mem_we    = issue & sel_we;
   assign mem_addr  = issue ? sel_addr  : '0;
   assign mem_wdata = issue ? sel_wdata : '0;

   if (ZERO_IDLE_RDATA) begin : g_rd_gated
      for (genvar g = 0; g < N_THREADS; g++) begin : g_lane
         assign thr_rdata[g*DATA_W +: DATA_W] = thr_done[g] ? mem_rdata : '0;
      end
   end else begin : g_rd_bcast
      for (genvar g = 0; g < N_THREADS; g++) begin : g_lane
         assign thr_rdata[g*DATA_W +: DATA_W] = mem_rdata;
      end
   end
endmodule

// File: rtl/mw_wheel_chk.sv
module mw_wheel_chk #(
   parameter int unsigned N   = 4,
   parameter int unsigned LAT = 13
) (
   input logic         clk,
   input logic         rst_n,
   input logic [N-1:0] thr_req,
   input logic [N-1:0] thr_grant,
   input logic [N-1:0] thr_done,
   input logic         mem_req
);
   localparam int unsigned CW = $clog2(LAT) + 1;

   logic          inflight;
   logic [CW-1:0] age;
   logic [N-1:0]  last_grant;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inflight   <= 1'b0;
         age        <= '0;
         last_grant <= '0;
      end else if (|thr_grant) begin
         inflight   <= 1'b1;
         age        <= '0;
         last_grant <= thr_grant;
      end else if (|thr_done) begin
         inflight   <= 1'b0;
      end else if (inflight) begin
         age        <= age + CW'(1);
      end
   end

   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(thr_grant));                                           // R2
   AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_grant & ~thr_req) == '0);                                  // R2
   AST_MEMREQ_IS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req == (|thr_grant));                                       // R3
   AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (|thr_done) |-> (inflight && age == CW'(LAT - 2)));             // R4
   AST_DONE_SAME_THREAD: assert property (@(posedge clk) disable iff (!rst_n)
      (|thr_done) |-> (thr_done == last_grant));                      // R4
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (|thr_done) |=> !(|thr_done));                                  // R4
   AST_NO_GRANT_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      inflight |-> !(|thr_grant));                                    // R8
endmodule

bind mem_wheel_arbiter mw_wheel_chk #(.N(N_THREADS), .LAT(MEM_LAT)) u_wheel_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .thr_req   (thr_req),
   .thr_grant (thr_grant),
   .thr_done  (thr_done),
   .mem_req   (mem_req)
);

// File: tb/tb_mem_wheel_arbiter.sv
module tb_mem_wheel_arbiter;
   localparam int CLK_PERIOD = 10;
   localparam int N   = 4;
   localparam int AW  = 16;
   localparam int DW  = 32;
   localparam int LAT = 13;
   localparam int WIN = 13;
   localparam int ROT = N * WIN;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    thr_req = '0;
   logic [N-1:0]    thr_we = '0;
   logic [N*AW-1:0] thr_addr = '0;
   logic [N*DW-1:0] thr_wdata = '0;
   logic [N-1:0]    thr_grant;
   logic [N-1:0]    thr_done;
   logic [N*DW-1:0] thr_rdata;
   logic            mem_req;
   logic            mem_we;
   logic [AW-1:0]   mem_addr;
   logic [DW-1:0]   mem_wdata;
   logic [DW-1:0]   mem_rdata;

   int errors = 0;
   int checks = 0;
   bit run = 1'b0;

   mem_wheel_arbiter #(
      .N_THREADS(N), .ADDR_W(AW), .DATA_W(DW), .MEM_LAT(LAT), .WIN_CYCLES(WIN)
   ) dut (
      .clk(clk), .rst_n(rst_n),
      .thr_req(thr_req), .thr_we(thr_we), .thr_addr(thr_addr), .thr_wdata(thr_wdata),
      .thr_grant(thr_grant), .thr_done(thr_done), .thr_rdata(thr_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural fixed-latency memory: data valid LAT-1 cycles after capture
   logic [DW-1:0] mem_arr [256];
   logic [DW-1:0] rd_q = '0;
   int            rd_cnt = 0;
   initial for (int i = 0; i < 256; i++) mem_arr[i] = 32'hA500_0000 | i;
   always @(posedge clk) begin
      if (mem_req) begin
         rd_q   <= mem_arr[mem_addr[7:0]];
         if (mem_we) mem_arr[mem_addr[7:0]] <= mem_wdata;
         rd_cnt <= LAT - 1;
      end else if (rd_cnt > 0) begin
         rd_cnt <= rd_cnt - 1;
      end
   end
   assign mem_rdata = (rd_cnt == 1) ? rd_q : 32'hDEAD_BEEF;

   // bench schedule model, derived from the requirements
   int m_slot = 0, m_owner = 0, cyc = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_slot <= 0; m_owner <= 0; cyc <= 0;
      end else begin
         cyc <= cyc + 1;
         if (m_slot == WIN - 1) begin
            m_slot <= 0;
            m_owner <= (m_owner + 1) % N;
         end else begin
            m_slot <= m_slot + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h (t=%0t)", rq, what, act, exp, $time);
      end
   endtask

   // reference memory and per-thread expectation
   logic [DW-1:0] ref_arr [256];
   initial for (int i = 0; i < 256; i++) ref_arr[i] = 32'hA500_0000 | i;
   bit            m_busy [N];
   bit            m_isrd [N];
   logic [DW-1:0] m_exp  [N];
   int            done_cnt [N];
   initial for (int i = 0; i < N; i++) begin
      m_busy[i] = 0; m_isrd[i] = 0; m_exp[i] = '0; done_cnt[i] = 0;
   end

   always @(negedge clk) begin
      logic [N-1:0] eg;
      logic [N-1:0] ed;
      if (rst_n && run) begin
         for (int i = 0; i < N; i++) begin
            eg[i] = (m_slot == 0) && (m_owner == i) && thr_req[i];
            ed[i] = m_busy[i] && (m_slot == LAT - 1);
         end
         chk(thr_grant == eg, "R2", "grant vector", 64'(thr_grant), 64'(eg));
         chk(mem_req == (|eg), "R3", "mem_req", 64'(mem_req), 64'(|eg));
         chk(thr_done == ed, "R4", "done vector", 64'(thr_done), 64'(ed));
         for (int i = 0; i < N; i++) begin
            if (eg[i]) begin
               chk(mem_addr == thr_addr[i*AW +: AW], "R3", "mem_addr",
                   64'(mem_addr), 64'(thr_addr[i*AW +: AW]));
               chk(mem_we == thr_we[i], "R3", "mem_we", 64'(mem_we), 64'(thr_we[i]));
               if (thr_we[i])
                  chk(mem_wdata == thr_wdata[i*DW +: DW], "R3", "mem_wdata",
                      64'(mem_wdata), 64'(thr_wdata[i*DW +: DW]));
               m_exp[i]  = ref_arr[thr_addr[i*AW +: 8]];
               m_isrd[i] = !thr_we[i];
               if (thr_we[i]) ref_arr[thr_addr[i*AW +: 8]] = thr_wdata[i*DW +: DW];
               m_busy[i] = 1'b1;
            end
            if (ed[i]) begin
               if (m_isrd[i])
                  chk(thr_rdata[i*DW +: DW] == m_exp[i], "R5", "read data",
                      64'(thr_rdata[i*DW +: DW]), 64'(m_exp[i]));
               m_busy[i] = 1'b0;
               done_cnt[i]++;
            end else begin
               chk(thr_rdata[i*DW +: DW] == '0, "R5", "idle rdata zero",
                   64'(thr_rdata[i*DW +: DW]), 64'h0);
            end
         end
      end
   end

   task automatic wait_slot(input int o, input int s);
      do begin
         @(posedge clk); #1;
      end while (!(m_owner == o && m_slot == s));
   endtask

   task automatic raise(input int i, input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
      thr_we[i] = w;
      thr_addr[i*AW +: AW] = a;
      thr_wdata[i*DW +: DW] = d;
      thr_req[i] = 1'b1;
   endtask

   task automatic wait_done(input int i, output int at);
      do @(negedge clk); while (!thr_done[i]);
      at = cyc;
   endtask

   task automatic drop_all();
      @(posedge clk); #1;
      thr_req = '0;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      int t0, td;
      int dc [N];
      int taken [N];
      void'($urandom(32'h5EED_0042));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      run = 1'b1;

      // R1: quiet first cycle at window 0, cycle 0
      @(negedge clk);
      chk(thr_grant == '0 && thr_done == '0 && !mem_req, "R1", "outputs after reset",
          64'({thr_grant, thr_done, mem_req}), 64'h0);
      chk(thr_rdata == '0, "R1", "rdata after reset", 64'(thr_rdata[DW-1:0]), 64'h0);

      // R6: request raised at cycle 2 of its own window waits a full rotation
      wait_slot(2, 2);
      raise(2, 1'b0, 16'h0005, '0);
      t0 = cyc;
      wait_done(2, td);
      chk(td - t0 == ROT - 2 + LAT - 1, "R6", "late request latency", 64'(td - t0),
          64'(ROT - 2 + LAT - 1));
      drop_all();

      // R2/R4: request present at window start is granted at once, done LAT-1 later
      wait_slot(1, 0);
      raise(1, 1'b1, 16'h0009, 32'h1234_5678);
      t0 = cyc;
      @(negedge clk);
      chk(thr_grant == 4'b0010, "R2", "on-time grant", 64'(thr_grant), 64'h2);
      wait_done(1, td);
      chk(td - t0 == LAT - 1, "R4", "done offset", 64'(td - t0), 64'(LAT - 1));
      drop_all();

      // R5: read back the written word through another thread
      raise(3, 1'b0, 16'h0009, '0);
      wait_done(3, td);
      chk(thr_rdata[3*DW +: DW] == 32'h1234_5678, "R5", "read after write",
          64'(thr_rdata[3*DW +: DW]), 64'h1234_5678);
      drop_all();

      // R7: idle windows of threads 1..3 are not lent to thread 0
      wait_slot(1, 0);
      raise(0, 1'b0, 16'h0003, '0);
      t0 = cyc;
      wait_done(0, td);
      chk(td - t0 == (N - 1) * WIN + LAT - 1, "R7", "idle windows skipped",
          64'(td - t0), 64'((N - 1) * WIN + LAT - 1));
      drop_all();

      // R7/R2: all threads request together; each served in its own window
      wait_slot(0, 0);
      for (int i = 0; i < N; i++) raise(i, 1'b0, AW'(i + 1), '0);
      t0 = cyc;
      for (int i = 0; i < N; i++) dc[i] = -1;
      repeat (ROT + 4) begin
         @(negedge clk);
         for (int i = 0; i < N; i++) if (thr_done[i] && dc[i] < 0) dc[i] = cyc;
         @(posedge clk); #1;
         for (int i = 0; i < N; i++) if (dc[i] >= 0) thr_req[i] = 1'b0;
      end
      chk(dc[0] - t0 == LAT - 1, "R7", "thread 0 latency under load",
          64'(dc[0] - t0), 64'(LAT - 1));
      chk(dc[N-1] - t0 == (N - 1) * WIN + LAT - 1, "R2", "last thread window",
          64'(dc[N-1] - t0), 64'((N - 1) * WIN + LAT - 1));
      thr_req = '0;

      // random traffic, held until done (R2..R5, R8 checked by the model)
      for (int i = 0; i < N; i++) taken[i] = done_cnt[i];
      repeat (3000) begin
         @(posedge clk); #1;
         for (int i = 0; i < N; i++) begin
            if (thr_req[i] && done_cnt[i] != taken[i]) begin
               taken[i] = done_cnt[i];
               thr_req[i] = 1'b0;
            end else if (!thr_req[i] && ($urandom % 5 == 0)) begin
               raise(i, 1'($urandom % 2), AW'($urandom % 16), $urandom);
            end
         end
      end
      thr_req = '0;
      repeat (ROT) @(posedge clk);
      run = 1'b0;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule